// File: doc/BRIEF.md
# Page Write Sequencer with Toggle Status

This block sits between a microcontroller bus interface and a nonvolatile memory array model. It collects byte writes that fall in one 32-byte page into a local buffer and keeps a load window open while writes keep coming. Each accepted write restarts that window. When the window runs out, the block runs a modelled programming cycle. During that cycle it hands each loaded byte to the array as a commit strobe, in ascending offset order, and reports itself busy.

Software tracks progress by reading status. While programming runs, bit 6 of the returned status flips on every read. Once programming is over, bit 6 holds its value. A write-control input lets the system cancel a page that is still being loaded. Both time constants are parameters counted in clock cycles.

Top module: `page_write_sequencer`

## Requirements
- R1: Each byte loaded into the open page is committed exactly once during programming, with its full address and its data. Commits come in ascending offset order, one per cycle, in the first PAGE_BYTES cycles of the programming phase. The page is selected by address bits [12:5] and the offset by bits [4:0].
- R2: Programming (`busy` high) begins exactly LOAD_CYCLES clock edges after the edge that accepted the last write of the page. Each write accepted into the page restarts this count, so up to 32 bytes can go into one page.
- R3: `busy` stays high for exactly PROG_CYCLES cycles, then falls.
- R4: Offsets of the page that were not written get no commit strobe.
- R5: A write with a different page address while a page is loading closes that page. Programming starts on that same edge, and the mismatched byte is dropped.
- R6: If `wc_inhibit` is high on any edge while a page is loading, the page is discarded: nothing is committed and `busy` stays low. A write presented while `wc_inhibit` is high is not accepted.
- R7: Writes presented while `busy` is high are ignored. They produce no commit and do not open a page afterwards.
- R8: Reads take effect as follows:
  - A read strobe updates `poll_data` on the next edge. Every bit except bit 6 is 0.
  - During programming, the first read returns bit 6 = 0, and each later read returns the inverse of the read before it.
- R9: When `busy` is low, successive reads return the same bit 6.
- R10: After reset, `busy`, `commit_en` and `poll_data` are all 0.
- R11: Writing the same offset twice in one page commits only the data of the later write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Status read strobe |
| wc_inhibit | input | 1 | High cancels a page still loading and blocks new writes |
| busy | output | 1 | Programming in progress |
| poll_data | output | DATA_W | Status from the last read; bit 6 is the toggle bit |
| commit_en | output | 1 | Commit strobe to the array model |
| commit_addr | output | ADDR_W | Address of the committed byte |
| commit_data | output | DATA_W | Data of the committed byte |

## Verification
The pages are exercised with several write patterns:
- A sparse page with a rewritten offset shows whether only loaded offsets are committed, and whether the later data wins.
- A full 32-byte page shows whether every write restarts the load window, rather than the window being counted from the first write.
- A page closed by an off-page write, followed by writes during programming, separates early closure from the normal timeout and shows whether writes are gated while busy.
- A page cancelled by the write-control input, followed by a fresh page at the same address, shows whether the cancel clears stale loaded bytes.

Status reads placed inside and outside programming tell toggling apart from a held bit 6.

// File: rtl/page_write_sequencer.sv
module page_write_sequencer #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 32,
  parameter int LOAD_CYCLES = 5000,
  parameter int PROG_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              wc_inhibit,
  output logic              busy,
  output logic [DATA_W-1:0] poll_data,
  output logic              commit_en,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFS_W;
  localparam int LT_W  = $clog2(LOAD_CYCLES + 1);
  localparam int PT_W  = $clog2(PROG_CYCLES + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} state_t;

  state_t                  st_q;
  logic [LT_W-1:0]         tmr_q;
  logic [PT_W-1:0]         prog_q;
  logic [PG_W-1:0]         page_q;
  logic [PAGE_BYTES-1:0]   mask_q;
  logic [DATA_W-1:0]       buf_q [PAGE_BYTES];
  logic                    tog_q;

  wire [OFS_W-1:0] wr_ofs  = wr_addr[OFS_W-1:0];
  wire [PG_W-1:0]  wr_pg   = wr_addr[ADDR_W-1:OFS_W];
  wire             same_pg = (wr_pg == page_q);
  wire             in_load = (st_q == S_LOAD);

  wire take        = wr_en && !wc_inhibit && ((st_q == S_IDLE) || (in_load && same_pg));
  wire close_early = in_load && !wc_inhibit && wr_en && !same_pg;
  wire load_done   = in_load && !wc_inhibit && !wr_en && (tmr_q == '0);
  wire discard     = in_load && wc_inhibit;
  wire enter_prog  = close_early || load_done;
  wire prog_last   = (st_q == S_PROG) && (prog_q == PT_W'(PROG_CYCLES - 1));

  wire [OFS_W-1:0] scan = prog_q[OFS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)                       st_q <= S_IDLE;
    else if (enter_prog)              st_q <= S_PROG;
    else if (discard || prog_last)    st_q <= S_IDLE;
    else if (take)                    st_q <= S_LOAD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       tmr_q <= '0;
    else if (take)                    tmr_q <= LT_W'(LOAD_CYCLES - 1);
    else if (in_load && tmr_q != '0)  tmr_q <= tmr_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st_q != S_PROG)     prog_q <= '0;
    else                              prog_q <= prog_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           page_q <= '0;
    else if (take && st_q == S_IDLE)      page_q <= wr_pg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || discard || prog_last)   mask_q <= '0;
    else if (take)                        mask_q[wr_ofs] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (take) buf_q[wr_ofs] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_q     <= 1'b0;
      poll_data <= '0;
    end else begin
      if (rd_en) begin
        poll_data    <= '0;
        poll_data[6] <= tog_q;
      end
      if (enter_prog)                  tog_q <= 1'b0;
      else if (rd_en && st_q == S_PROG) tog_q <= ~tog_q;
    end
  end

  assign busy        = (st_q == S_PROG);
  assign commit_en   = busy && (prog_q < PT_W'(PAGE_BYTES)) && mask_q[scan];
  assign commit_addr = {page_q, scan};
  assign commit_data = buf_q[scan];
endmodule

module page_write_sequencer_chk #(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 250000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wc_inhibit,
  input logic              busy,
  input logic [DATA_W-1:0] poll_data,
  input logic              commit_en,
  input logic [ADDR_W-1:0] commit_addr
);
  logic [31:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= '0;
  end

  a_r1_commit_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> busy);
  a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == PROG_CYCLES);
  a_r8_poll_held: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(poll_data));
  a_r6_inhibit_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wc_inhibit && !busy) |=> !busy);
  a_r7_page_fixed_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(commit_addr[ADDR_W-1:5]));
endmodule

bind page_write_sequencer page_write_sequencer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (.*);

// File: tb/sim_page_write_sequencer.sv
module sim_page_write_sequencer;
  localparam int L = 8;
  localparam int P = 40;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, wc_inhibit = 0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic busy, commit_en;
  logic [7:0]  poll_data, commit_data;
  logic [12:0] commit_addr;

  page_write_sequencer #(.LOAD_CYCLES(L), .PROG_CYCLES(P)) u0 (.*);

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0, run = 0;
  logic [20:0] exp_q [$];
  bit exp_tog;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=%0d expected=finish", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (commit_en) begin
      if (exp_q.size() == 0) chk("R4/R7 unexpected commit", {commit_addr, commit_data}, 0);
      else chk("R1 commit addr/data", {commit_addr, commit_data}, exp_q.pop_front());
    end
    if (busy) run++;
    else if (run != 0) begin chk("R3 busy length", run, P); run = 0; end
  end

  task automatic wr(int pg, int ofs, int d);
    @(negedge clk); wr_en = 1; wr_addr = 13'((pg << 5) | ofs); wr_data = 8'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic push(int pg, int ofs, int d);
    exp_q.push_back({13'((pg << 5) | ofs), 8'(d)});
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0; v = poll_data;
  endtask

  task automatic check_start(string tag);
    repeat (L - 1) @(negedge clk);
    chk({tag, " busy before window end"}, busy, 0);
    @(negedge clk);
    chk({tag, " busy at window end"}, busy, 1);
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v, v2;
    repeat (3) @(negedge clk);
    chk("R10 busy after reset", busy, 0);
    chk("R10 commit after reset", commit_en, 0);
    chk("R10 poll after reset", poll_data, 0);
    rst_n = 1;

    // sparse page with rewrite (R1, R2, R4, R11, R8)
    push(5, 0, 8'h11); push(5, 3, 8'h3b); push(5, 31, 8'hf1);
    wr(5, 0, 8'h11); wr(5, 3, 8'h3a); wr(5, 31, 8'hf1); wr(5, 3, 8'h3b);
    check_start("R2");
    exp_tog = 0;
    for (int i = 0; i < 3; i++) begin
      rd(v);
      chk("R8 toggle bit during programming", v[6], exp_tog);
      chk("R8 other status bits", v & 8'hbf, 0);
      exp_tog = ~exp_tog;
    end
    wait_idle();
    chk("R11/R1 queue drained", exp_q.size(), 0);
    rd(v); rd(v2);
    chk("R9 idle bit6 stable", v2[6], v[6]);
    rd(v2);
    chk("R9 idle bit6 stable again", v2[6], v[6]);

    // full page, every write restarts window (R2)
    for (int i = 0; i < 32; i++) begin push(100, i, 8'(i * 7 + 1)); wr(100, i, 8'(i * 7 + 1)); end
    check_start("R2 full page");
    wait_idle();
    chk("R1 full page drained", exp_q.size(), 0);

    // early close (R5), writes while busy (R7)
    push(7, 1, 8'h71); push(7, 2, 8'h72);
    wr(7, 1, 8'h71); wr(7, 2, 8'h72); wr(9, 0, 8'h90);
    chk("R5 programming starts on off-page write", busy, 1);
    wr(9, 5, 8'h95);
    wait_idle();
    repeat (L + 5) @(negedge clk);
    chk("R7 no page opened by busy-time write", busy, 0);
    chk("R5 queue drained", exp_q.size(), 0);

    // write-control cancel (R6)
    wr(3, 4, 8'h34);
    @(negedge clk); wc_inhibit = 1;
    @(negedge clk); wc_inhibit = 0;
    repeat (L + 5) @(negedge clk);
    chk("R6 cancelled page not programmed", busy, 0);
    @(negedge clk); wc_inhibit = 1;
    wr(3, 9, 8'h39);
    @(negedge clk); wc_inhibit = 0;
    repeat (L + 5) @(negedge clk);
    chk("R6 inhibited write not accepted", busy, 0);
    push(3, 6, 8'h36);
    wr(3, 6, 8'h36);
    check_start("R6 fresh page");
    rd(v);
    chk("R8 first read after start", v[6], 0);
    wait_idle();
    chk("R4/R6 only fresh byte committed", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule